// File: doc/BRIEF.md
# Byte-Order Mode State Register

This block holds the byte-order control state of a processor core. The state has two control bits: a current-mode bit that tells the load/store path whether accesses run little-endian, and an interrupt-mode bit that chooses the byte order in which interrupt handlers run. Next to these two bits sits a generic pass-through field for other status bits. Privileged software writes the whole state word through a simple write port. Each process can therefore run in its own byte order, and every later load and store follows the new mode.

When an interrupt is taken, the block copies the complete current state into a single save register. It then loads a handler state. In the handler state the current-mode bit takes the old interrupt-mode bit, the interrupt-mode bit keeps its value, and the other field comes from a fixed handler template input. A handler can therefore run in a different byte order from the code it interrupted. On return from interrupt, the saved word is reloaded unchanged.

Requests have a fixed priority. Interrupt entry comes first, return second and software write last. A request that loses in a cycle is dropped. Every change becomes visible at the outputs one clock after the request.

Top module: `endian_mode_state`

## Requirements
- R1: A synchronous active-high reset clears the current state and the save register to all zeros, so the block leaves reset in big-endian mode (`le_mode` = 0, `state_q` = 0).
- R2: The state word is laid out as follows: bit 0 is the current-mode bit (1 = little-endian), bit 1 is the interrupt-mode bit, and bits 7:2 are the pass-through field. `le_mode` always equals bit 0 of `state_q`.
- R3: A write with `wr_en` = 1, and with neither interrupt request active, puts `wr_data` into `state_q` at the next clock edge.
- R4: With `irq_take` = 1, the next state has bit 0 equal to the old bit 1, bit 1 unchanged, and bits 7:2 equal to `handler_tmpl`. The save register receives the complete old state in the same edge.
- R5: With `irq_return` = 1 and `irq_take` = 0, the next state equals the save register word, both control bits included.
- R6: When `irq_take` and `irq_return` are both 1, only the entry is performed and the return has no effect.
- R7: A write that coincides with `irq_take` or `irq_return` is dropped. The resulting state is exactly what the interrupt operation alone would produce.
- R8: With no request active, `state_q` holds its value.
- R9: The save register changes only on interrupt entry. Writes and returns leave it as it was, which shows at the next return.
- R10: Saving is single-level. A second entry before a return overwrites the saved word with the handler state that was current, and a later return restores that word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Software write request |
| wr_data | input | 8 | State word to write |
| irq_take | input | 1 | Interrupt entry request |
| irq_return | input | 1 | Return-from-interrupt request |
| handler_tmpl | input | 6 | Pass-through field loaded on interrupt entry |
| le_mode | output | 1 | Current mode to the load/store path, 1 = little-endian |
| state_q | output | 8 | Current state word |

## Verification
A wrong current state shows up at `state_q` and `le_mode` one clock after the request that caused it. The bench model compares both outputs on every cycle, so such an error is caught at once. A corrupted or wrongly updated save register stays hidden until the next return. For this reason the sequences place writes, nested entries and same-cycle conflicts between entry and return, so that every path into the save register is later exposed at the outputs. A wrong priority changes the state in the cycle that follows the conflict.

// File: rtl/endian_state_pkg.sv
package endian_state_pkg;

    localparam int MISC_W  = 6;
    localparam int STATE_W = MISC_W + 2;

    typedef struct packed {
        logic [MISC_W-1:0] misc;
        logic              ile;
        logic              le;
    } mode_state_t;

    typedef enum logic [1:0] {
        OP_HOLD   = 2'd0,
        OP_WRITE  = 2'd1,
        OP_ENTER  = 2'd2,
        OP_RETURN = 2'd3
    } state_op_e;

    function automatic mode_state_t make_handler_state(
        input mode_state_t       old_s,
        input logic [MISC_W-1:0] tmpl
    );
        mode_state_t n;
        n.le   = old_s.ile;
        n.ile  = old_s.ile;
        n.misc = tmpl;
        return n;
    endfunction

endpackage

// File: rtl/endian_op_arb.sv
module endian_op_arb
    import endian_state_pkg::*;
(
    input  logic      wr_en,
    input  logic      irq_take,
    input  logic      irq_return,
    output state_op_e op
);
    always_comb begin
        if (irq_take)        op = OP_ENTER;
        else if (irq_return) op = OP_RETURN;
        else if (wr_en)      op = OP_WRITE;
        else                 op = OP_HOLD;
    end

    always_comb begin
        if (irq_take) assert_entry_wins_R6: assert (op == OP_ENTER);
    end
endmodule

// File: rtl/endian_entry_gen.sv
module endian_entry_gen
    import endian_state_pkg::*;
(
    input  mode_state_t       cur_s,
    input  logic [MISC_W-1:0] tmpl,
    output mode_state_t       entry_s
);
    assign entry_s = make_handler_state(cur_s, tmpl);
endmodule

// File: rtl/endian_state_regs.sv
module endian_state_regs
    import endian_state_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  state_op_e   op,
    input  mode_state_t wr_s,
    input  mode_state_t entry_s,
    output mode_state_t cur_q,
    output mode_state_t save_q
);
    mode_state_t cur_d;
    mode_state_t save_d;

    always_comb begin
        cur_d  = cur_q;
        save_d = save_q;
        unique case (op)
            OP_ENTER: begin
                save_d = cur_q;
                cur_d  = entry_s;
            end
            OP_RETURN: cur_d = save_q;
            OP_WRITE:  cur_d = wr_s;
            default:   ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q  <= '0;
            save_q <= '0;
        end else begin
            cur_q  <= cur_d;
            save_q <= save_d;
        end
    end

    assert_save_only_on_entry_R9: assert property (@(posedge clk) disable iff (rst)
        (op != OP_ENTER) |=> $stable(save_q));

    assert_return_restores_R5: assert property (@(posedge clk) disable iff (rst)
        (op == OP_RETURN) |=> (cur_q == $past(save_q)));
endmodule

// File: rtl/endian_mode_state.sv
module endian_mode_state
    import endian_state_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic [STATE_W-1:0] wr_data,
    input  logic               irq_take,
    input  logic               irq_return,
    input  logic [MISC_W-1:0]  handler_tmpl,
    output logic               le_mode,
    output logic [STATE_W-1:0] state_q
);
    state_op_e   op;
    mode_state_t cur_s;
    mode_state_t save_s;
    mode_state_t entry_s;

    endian_op_arb u_arb (
        .wr_en      (wr_en),
        .irq_take   (irq_take),
        .irq_return (irq_return),
        .op         (op)
    );

    endian_entry_gen u_entry (
        .cur_s   (cur_s),
        .tmpl    (handler_tmpl),
        .entry_s (entry_s)
    );

    endian_state_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .op      (op),
        .wr_s    (mode_state_t'(wr_data)),
        .entry_s (entry_s),
        .cur_q   (cur_s),
        .save_q  (save_s)
    );

    assign state_q = cur_s;
    assign le_mode = cur_s.le;

    assert_entry_mode_R4: assert property (@(posedge clk) disable iff (rst)
        irq_take |=> (state_q[0] == $past(state_q[1])) && (state_q[1] == $past(state_q[1]))
                     && (state_q[STATE_W-1:2] == $past(handler_tmpl)));

    assert_entry_save_R4: assert property (@(posedge clk) disable iff (rst)
        irq_take |=> (save_s == $past(cur_s)));

    assert_write_R3: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !irq_take && !irq_return) |=> (state_q == $past(wr_data)));

    assert_idle_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (!wr_en && !irq_take && !irq_return) |=> $stable(state_q));

    assert_write_dropped_R7: assert property (@(posedge clk) disable iff (rst)
        (wr_en && irq_return && !irq_take) |=> (state_q == $past(save_s)));
endmodule

// File: tb/endian_mode_state_test.sv
module endian_mode_state_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic       irq_take = 1'b0;
    logic       irq_return = 1'b0;
    logic [5:0] handler_tmpl = '0;
    logic       le_mode;
    logic [7:0] state_q;

    int vectors = 0;
    int errors  = 0;
    bit done    = 0;

    int m_cur  = 0;
    int m_save = 0;

    always #5 clk = ~clk;

    endian_mode_state uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
        .irq_take(irq_take), .irq_return(irq_return),
        .handler_tmpl(handler_tmpl), .le_mode(le_mode), .state_q(state_q)
    );

    task automatic compare(input string tag);
        vectors++;
        if (state_q !== m_cur[7:0]) begin
            errors++;
            $display("FAIL %s: state_q actual %02h expected %02h", tag, state_q, m_cur[7:0]);
        end
        vectors++;
        if (le_mode !== m_cur[0]) begin
            errors++;
            $display("FAIL R2: le_mode actual %0b expected %0b", le_mode, m_cur[0]);
        end
    endtask

    // Called at a falling edge: drive, advance the model, wait one cycle, compare.
    task automatic step(input bit w, input int wd, input bit t, input bit r,
                        input int tmpl, input string force_tag);
        string tag;
        wr_en = w; wr_data = wd[7:0]; irq_take = t; irq_return = r;
        handler_tmpl = tmpl[5:0];
        if (t && (r || w))  tag = (r ? "R6" : "R7");
        else if (t)         tag = "R4";
        else if (r && w)    tag = "R7";
        else if (r)         tag = "R5";
        else if (w)         tag = "R3";
        else                tag = "R8";
        if (force_tag != "") tag = force_tag;
        if (t) begin
            int oi;
            oi     = (m_cur >> 1) & 1;
            m_save = m_cur;
            m_cur  = ((tmpl & 63) << 2) | (oi << 1) | oi;
        end else if (r) begin
            m_cur = m_save;
        end else if (w) begin
            m_cur = wd & 255;
        end
        @(negedge clk);
        compare(tag);
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not end, actual running expected done");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        compare("R1");
        rst = 1'b0;
        // Process runs little-endian, handler mode little-endian
        step(1, 8'h03, 0, 0, 0, "");
        step(0, 0, 0, 0, 0, "R8");
        step(0, 0, 1, 0, 6'h15, "R4");
        // Handler changes mode by write; save register must survive (R9)
        step(1, 8'hA0, 0, 0, 0, "");
        step(0, 0, 0, 1, 0, "R9");
        // Big-endian process with little-endian handlers
        step(1, 8'h02, 0, 0, 0, "");
        step(0, 0, 1, 0, 6'h3F, "R4");
        step(0, 0, 0, 1, 0, "R5");
        // Little-endian process with big-endian handlers
        step(1, 8'hF1, 0, 0, 0, "");
        step(0, 0, 1, 0, 6'h00, "R4");
        step(0, 0, 0, 1, 0, "R5");
        // Entry and return together: entry wins
        step(0, 0, 1, 1, 6'h2A, "R6");
        step(0, 0, 0, 1, 0, "R6");
        // Write dropped under entry and under return
        step(1, 8'h55, 1, 0, 6'h11, "R7");
        step(1, 8'hFF, 0, 1, 0, "R7");
        // Nested entry overwrites save
        step(1, 8'h06, 0, 0, 0, "");
        step(0, 0, 1, 0, 6'h01, "R10");
        step(0, 0, 1, 0, 6'h02, "R10");
        step(0, 0, 0, 1, 0, "R10");
        step(0, 0, 0, 1, 0, "R10");
        // Mid-run reset
        rst = 1'b1;
        m_cur = 0; m_save = 0;
        @(negedge clk);
        compare("R1");
        rst = 1'b0;
        step(0, 0, 0, 1, 0, "R1");
        // Random traffic
        for (int i = 0; i < 3000; i++) begin
            int sel;
            sel = $urandom_range(0, 9);
            step(sel < 4, $urandom_range(0, 255), sel == 4 || sel == 7,
                 sel == 5 || sel == 7 || sel == 8, $urandom_range(0, 63), "");
        end
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule